// File: doc/BRIEF.md
# Packed Subword SIMD ALU

This execution unit treats each of two 64-bit operands as a packed vector of narrow integers. A two-bit size code selects 8-bit, 16-bit or 32-bit elements. The width of the operands is a parameter, so the lane count is a derived value. The unit offers these operations:

- wrapping add and subtract, carried out lane by lane
- add and subtract that clamp each lane to its range
- element-wise minimum and maximum
- compares that write a full-lane mask of all ones or all zeros
- a sum of absolute byte differences that collapses to one scalar
- a narrowing pack that turns signed halfwords into saturated bytes

A signedness input picks how lanes are read for clamping, ordering and packing.

Each operation is presented with a one-cycle valid strobe. The result and its valid flag leave a single register stage on the next clock. A new operation can be issued on every cycle. When no strobe is present, the output register keeps its last value.

Top module: `simd_alu`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `result` holds that operation's result. Back-to-back strobes give back-to-back results.
- R2: After reset, `out_valid` is 0 and `result` is 0. In a cycle without a strobe, `out_valid` goes low and `result` keeps its previous value.
- R3: Size codes are 0 = 8-bit lanes, 1 = 16-bit lanes, 2 = 32-bit lanes, and the reserved code 3 behaves as 32-bit. Lane i occupies bits [i*W +: W]. Opcode 0 (add) and opcode 1 (sub, opa minus opb) wrap modulo 2^W in each lane, and no carry or borrow crosses a lane boundary.
- R4: Opcode 2 (add) and opcode 3 (sub) saturate per lane. With `sgn`=1 the bounds are -2^(W-1)..2^(W-1)-1 in two's complement. With `sgn`=0 the bounds are 0..2^W-1.
- R5: Opcode 4 returns the per-lane minimum and opcode 5 the per-lane maximum. Lanes are compared as signed when `sgn`=1 and as unsigned otherwise.
- R6: Opcode 6 (equal) and opcode 7 (opa greater than opb, with signedness from `sgn`) write all ones into a lane where the condition holds and all zeros where it does not.
- R7: Opcode 8 sums |opa byte - opb byte| over all bytes, with bytes read as unsigned. The sum is zero-extended into `result`. The size code and `sgn` have no effect.
- R8: Opcode 9 reads opa halfwords 0..3 and opb halfwords 0..3 as signed. It writes them to result bytes 0..3 and 4..7 respectively. With `sgn`=1 each value saturates to -128..127. With `sgn`=0 each value saturates to 0..255. The size code has no effect.
- R9: Opcodes 10 to 15 produce an all-zero result with `out_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Opcode |
| esize | input | 2 | Element size code |
| sgn | input | 1 | 1 = signed lane interpretation |
| opa | input | 64 | First packed operand |
| opb | input | 64 | Second packed operand |
| out_valid | output | 1 | Result valid, one clock after the strobe |
| result | output | 64 | Registered packed result |

## Verification
The hardest cases to reach are lanes that sit exactly at a saturation bound or straddle a carry boundary while their neighbours hold different values. Random operands almost never produce them. The stimulus therefore builds each operand lane by lane from a table of boundary values: zero, one, both signed extremes, the value above the negative extreme, all ones, and all ones minus one. A different rotation of the table is applied to each operand, so every lane pairs a distinct extreme with a distinct partner at every size. Idle cycles carrying junk inputs are mixed into the stream to show that the output register holds.

// File: rtl/simd_pkg.sv
package simd_pkg;
   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_ADDS = 4'd2,
      OP_SUBS = 4'd3,
      OP_MIN  = 4'd4,
      OP_MAX  = 4'd5,
      OP_CEQ  = 4'd6,
      OP_CGT  = 4'd7,
      OP_SAD  = 4'd8,
      OP_PACK = 4'd9
   } op_e;

   localparam int NUM_SIZES = 3;
endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [3:0]   op,
   input  logic         sgn,
   output logic [W-1:0] r
);
   import simd_pkg::*;

   localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

   logic [W:0]   usum, udif, ssum, sdif;
   logic         gt;
   logic [W-1:0] sat_add, sat_sub;

   assign usum = {1'b0, a} + {1'b0, b};
   assign udif = {1'b0, a} - {1'b0, b};
   assign ssum = {a[W-1], a} + {b[W-1], b};
   assign sdif = {a[W-1], a} - {b[W-1], b};
   assign gt   = sgn ? ($signed(a) > $signed(b)) : (a > b);

   always_comb begin
      if (sgn)
         sat_add = (ssum[W] != ssum[W-1]) ? (ssum[W] ? SMIN : SMAX) : ssum[W-1:0];
      else
         sat_add = usum[W] ? {W{1'b1}} : usum[W-1:0];
      if (sgn)
         sat_sub = (sdif[W] != sdif[W-1]) ? (sdif[W] ? SMIN : SMAX) : sdif[W-1:0];
      else
         sat_sub = udif[W] ? {W{1'b0}} : udif[W-1:0];
   end

   always_comb begin
      case (op)
         OP_ADD:  r = usum[W-1:0];
         OP_SUB:  r = udif[W-1:0];
         OP_ADDS: r = sat_add;
         OP_SUBS: r = sat_sub;
         OP_MIN:  r = gt ? b : a;
         OP_MAX:  r = gt ? a : b;
         OP_CEQ:  r = (a == b) ? {W{1'b1}} : {W{1'b0}};
         OP_CGT:  r = gt ? {W{1'b1}} : {W{1'b0}};
         default: r = {W{1'b0}};
      endcase
   end
endmodule

// File: rtl/simd_sad.sv
module simd_sad #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] sum
);
   localparam int NB   = DATA_W / 8;
   localparam int SADW = $clog2(NB * 255 + 1);

   logic [SADW-1:0] acc;

   always_comb begin
      acc = '0;
      for (int i = 0; i < NB; i++) begin
         if (a[i*8 +: 8] > b[i*8 +: 8])
            acc = acc + SADW'(a[i*8 +: 8] - b[i*8 +: 8]);
         else
            acc = acc + SADW'(b[i*8 +: 8] - a[i*8 +: 8]);
      end
   end

   assign sum = DATA_W'(acc);
endmodule

// File: rtl/simd_pack.sv
module simd_pack #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sgn,
   output logic [DATA_W-1:0] packed_out
);
   localparam int NH = DATA_W / 16;

   function automatic logic [7:0] narrow(input logic [15:0] h, input logic s);
      logic signed [15:0] v;
      v = $signed(h);
      if (s) begin
         if (v > 16'sd127)       narrow = 8'h7F;
         else if (v < -16'sd128) narrow = 8'h80;
         else                    narrow = h[7:0];
      end else begin
         if (v < 16'sd0)         narrow = 8'h00;
         else if (v > 16'sd255)  narrow = 8'hFF;
         else                    narrow = h[7:0];
      end
   endfunction

   for (genvar j = 0; j < NH; j++) begin : g_hw
      assign packed_out[j*8 +: 8]        = narrow(a[j*16 +: 16], sgn);
      assign packed_out[(j+NH)*8 +: 8]   = narrow(b[j*16 +: 16], sgn);
   end
endmodule

// File: rtl/simd_alu.sv
module simd_alu #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        op,
   input  logic [1:0]        esize,
   input  logic              sgn,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);
   import simd_pkg::*;

   if (DATA_W % 32 != 0 || DATA_W < 32) begin : g_bad_width
      $error("simd_alu: DATA_W must be a positive multiple of 32");
   end

   logic [NUM_SIZES-1:0][DATA_W-1:0] by_size;
   logic [DATA_W-1:0] sad_val, pack_val, next_res;
   logic [1:0]        sel;

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
      localparam int W = 8 << g;
      localparam int N = DATA_W / W;
      for (genvar l = 0; l < N; l++) begin : g_lane
         simd_lane #(.W(W)) u_lane (
            .a   (opa[l*W +: W]),
            .b   (opb[l*W +: W]),
            .op  (op),
            .sgn (sgn),
            .r   (by_size[g][l*W +: W])
         );
      end
   end

   simd_sad #(.DATA_W(DATA_W)) u_sad (
      .a   (opa),
      .b   (opb),
      .sum (sad_val)
   );

   simd_pack #(.DATA_W(DATA_W)) u_pack (
      .a          (opa),
      .b          (opb),
      .sgn        (sgn),
      .packed_out (pack_val)
   );

   assign sel = (esize == 2'd3) ? 2'd2 : esize;

   always_comb begin
      if (op == OP_SAD)
         next_res = sad_val;
      else if (op == OP_PACK)
         next_res = pack_val;
      else if (op <= OP_CGT)
         next_res = by_size[sel];
      else
         next_res = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= next_res;
      end
   end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        op,
   input logic              sgn,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic              out_valid,
   input logic [DATA_W-1:0] result
);
   localparam int SADW = $clog2((DATA_W / 8) * 255 + 1);

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_novalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   assert_add_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd0 && opb == '0) |=> result == $past(opa));

   assert_usat_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd2 && !sgn && opb == '0) |=> result == $past(opa));

   assert_eq_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd6 && opa == opb) |=> result == {DATA_W{1'b1}});

   assert_sad_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 4'd8) |=> result[DATA_W-1:SADW] == '0);

   assert_unused_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op >= 4'd10) |=> result == '0);
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op        (op),
   .sgn       (sgn),
   .opa       (opa),
   .opb       (opb),
   .out_valid (out_valid),
   .result    (result)
);

// File: tb/simd_alu_test.sv
module simd_alu_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op = '0;
   logic [1:0]  esize = '0;
   logic        sgn = 1'b0;
   logic [63:0] opa = '0, opb = '0;
   logic        out_valid;
   logic [63:0] result;

   int checks = 0;
   int failures = 0;
   logic [63:0] exp_res = '0;
   bit          exp_valid = 1'b0;
   string       exp_tag = "R2";
   int          step_cnt = 0;

   always #5 clk = ~clk;

   simd_alu #(.DATA_W(64)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esize(esize),
      .sgn(sgn), .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
   );

   function automatic int lane_w(input int s);
      return (s == 0) ? 8 : (s == 1) ? 16 : 32;
   endfunction

   function automatic string tag_of(input int o);
      if (o <= 1) return "R3";
      if (o <= 3) return "R4";
      if (o <= 5) return "R5";
      if (o <= 7) return "R6";
      if (o == 8) return "R7";
      if (o == 9) return "R8";
      return "R9";
   endfunction

   function automatic longint clampv(input longint v, input longint lo, input longint hi);
      return (v < lo) ? lo : (v > hi) ? hi : v;
   endfunction

   function automatic logic [63:0] model(input int o, input int s, input bit g,
                                         input logic [63:0] a, input logic [63:0] b);
      logic [63:0] res = '0;
      int w = lane_w(s);
      longint m = (longint'(1) <<< w) - 1;
      longint hi = g ? (longint'(1) <<< (w-1)) - 1 : m;
      longint lo = g ? -(longint'(1) <<< (w-1)) : 0;
      if (o <= 7) begin
         for (int i = 0; i < 64 / w; i++) begin
            longint ua = longint'((a >> (i*w))) & m;
            longint ub = longint'((b >> (i*w))) & m;
            longint sa = (ua > (m >> 1)) ? ua - m - 1 : ua;
            longint sb = (ub > (m >> 1)) ? ub - m - 1 : ub;
            longint x = g ? sa : ua;
            longint y = g ? sb : ub;
            longint r;
            case (o)
               0: r = ua + ub;
               1: r = ua - ub;
               2: r = clampv(x + y, lo, hi);
               3: r = clampv(x - y, lo, hi);
               4: r = (x < y) ? x : y;
               5: r = (x > y) ? x : y;
               6: r = (ua == ub) ? -1 : 0;
               default: r = (x > y) ? -1 : 0;
            endcase
            res = res | ((64'(r) & 64'(m)) << (i*w));
         end
      end else if (o == 8) begin
         longint acc = 0;
         for (int i = 0; i < 8; i++) begin
            longint ua = longint'(a[i*8 +: 8]);
            longint ub = longint'(b[i*8 +: 8]);
            acc += (ua > ub) ? ua - ub : ub - ua;
         end
         res = 64'(acc);
      end else if (o == 9) begin
         for (int i = 0; i < 8; i++) begin
            logic [15:0] h = (i < 4) ? a[i*16 +: 16] : b[(i-4)*16 +: 16];
            longint v = longint'($signed(h));
            longint r = g ? clampv(v, -128, 127) : clampv(v, 0, 255);
            res[i*8 +: 8] = 8'(r);
         end
      end
      return res;
   endfunction

   function automatic longint corner(input int k, input int w);
      longint m = (longint'(1) <<< w) - 1;
      case (k)
         0: return 0;
         1: return 1;
         2: return m >> 1;
         3: return (m >> 1) + 1;
         4: return (m >> 1) + 2;
         5: return m;
         6: return m - 1;
         default: return longint'(1) <<< (w-2);
      endcase
   endfunction

   task automatic step(input int o, input int s, input bit g,
                       input logic [63:0] x, input logic [63:0] y, input bit v);
      @(negedge clk);
      checks++;
      if (out_valid !== exp_valid || result !== exp_res) begin
         failures++;
         $display("FAIL %s: valid=%0b result=%h expected valid=%0b result=%h",
                  exp_valid ? exp_tag : "R2", out_valid, result, exp_valid, exp_res);
      end
      in_valid = v; op = 4'(o); esize = 2'(s); sgn = g; opa = x; opb = y;
      if (v) begin
         exp_res = model(o, s, g, x, y);
         exp_tag = tag_of(o);
      end
      exp_valid = v;
      step_cnt++;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #1_500_000;
      failures++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2: reset state observed through the first step's check
      rst_n = 1'b1;
      for (int o = 0; o < 12; o++)
         for (int g = 0; g < 2; g++)
            for (int s = 0; s < 4; s++) begin
               int w = lane_w(s);
               for (int k = 0; k < 8; k++)
                  for (int j = 0; j < 8; j++) begin
                     logic [63:0] x = '0, y = '0;
                     for (int i = 0; i < 64 / w; i++) begin
                        x = x | (64'(corner((i + k) % 8, w)) << (i*w));
                        y = y | (64'(corner((i*3 + j) % 8, w)) << (i*w));
                     end
                     step(o, s, g[0], x, y, 1'b1);
                     // R2: idle cycle with junk inputs must hold the result
                     if (((k * 8 + j) % 13) == 5)
                        step(o, s, g[0], {$urandom, $urandom}, {$urandom, $urandom}, 1'b0);
                  end
               for (int n = 0; n < 40; n++)
                  step(o, s, g[0], {$urandom, $urandom}, {$urandom, $urandom}, 1'b1);
            end
      step(0, 0, 1'b0, '0, '0, 1'b0);
      step(0, 0, 1'b0, '0, '0, 1'b0);
      finish_run();
   end
endmodule